// File: doc/BRIEF.md
# Global-History Gselect Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a table of two-bit saturating counters. A counter is chosen by joining a few low bits of the branch address with a short shift register of recent global branch outcomes. Because the history is part of the index, a single branch can use different counters in different history contexts. That lets it learn short repeating patterns such as the exit of a small inner loop.

The lookup side is purely combinational. A fetch stage presents a branch address and, in the same cycle, gets back three things: the direction, the counter behind that direction, and the history value used to form the index. The fetch stage carries that history value along with the branch.

When the branch resolves, the update side receives four inputs: the branch address, the carried history, the actual outcome, and a valid strobe. On the next clock edge, the counter selected by that address and carried history is trained, and the outcome is shifted into the global history. Only addresses and outcomes feed the predictor; operand values play no part in it.

Top module: `gsel_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not-taken) and the global history is all zeros, so every lookup returns not-taken with counter 01 and history 0.
- R2: The selected entry is {addr[ALIGN+ADDR_BITS-1:ALIGN], history}, with the address bits in the upper part of the index. Address bits below ALIGN and above ALIGN+ADDR_BITS-1 have no effect on which entry is chosen.
- R3: A valid update with outcome taken (1) increments the selected counter, stopping at 3.
- R4: A valid update with outcome not-taken (0) decrements the selected counter, stopping at 0.
- R5: A lookup answers in the same cycle. The predicted direction is the counter's upper bit, the counter value is shown on its own output, and the history output is the current global history.
- R6: On each valid update the global history shifts one place toward the upper bit. The outcome enters bit 0 and the oldest bit is dropped.
- R7: When the update strobe is low, neither the counters nor the history change, however many lookups take place.
- R8: An update trains the entry selected by the supplied history, not by the global history present at update time.
- R9: When a lookup and an update select the same entry in one cycle, the lookup returns the counter value from before the update. The trained value is visible from the next cycle.
- R10: A branch whose outcomes repeat 1,1,1,0 learns the pattern: once trained, it predicts not-taken when history ends in 0111 and taken when history ends in 1110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_addr_i | input | ADDR_W | Branch address to predict |
| lk_pred_o | output | 1 | Predicted direction, 1 = taken |
| lk_ctr_o | output | 2 | Counter value behind the prediction |
| lk_hist_o | output | HIST_LEN | Global history used for this lookup |
| up_valid_i | input | 1 | Resolved branch present this cycle |
| up_addr_i | input | ADDR_W | Address of the resolved branch |
| up_hist_i | input | HIST_LEN | History value that was carried from lookup |
| up_taken_i | input | 1 | Actual outcome, 1 = taken |

## Verification
A wrong counter stays hidden until a lookup reaches its entry with a matching history. The bench therefore steers the global history on purpose and sweeps every address slice under it. Off-by-one counter steps and missing saturation show up on the counter output in the first lookup after the faulty update.

A wrong history shift is different. It shows on the history output one cycle after the update. From then on it moves every lookup onto a different entry, so the reference model diverges at once. A wrong collision behaviour shows only in the cycle of the collision itself, which is why the bench samples that cycle before the clock edge.

// File: rtl/gsel_pkg.sv
package gsel_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'b01;
  localparam ctr_t CTR_MAX  = 2'b11;
  localparam ctr_t CTR_MIN  = 2'b00;

  // Saturating step of a two-bit confidence counter.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else       nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/gsel_index_gen.sv
module gsel_index_gen #(
  parameter int ADDR_W    = 32,
  parameter int ALIGN     = 2,
  parameter int ADDR_BITS = 4,
  parameter int HIST_LEN  = 4,
  localparam int IDX_W    = ADDR_BITS + HIST_LEN
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [HIST_LEN-1:0] hist_i,
  output logic [IDX_W-1:0]    idx_o
);

  logic [ADDR_BITS-1:0] addr_slice;
  logic                 unused_addr_bits;

  assign addr_slice       = addr_i[ALIGN +: ADDR_BITS];
  assign unused_addr_bits = ^{addr_i[ADDR_W-1:ALIGN+ADDR_BITS], addr_i[ALIGN-1:0]};
  assign idx_o            = {addr_slice, hist_i};

endmodule

// File: rtl/gsel_history.sv
module gsel_history #(
  parameter int HIST_LEN = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                bit_in,
  output logic [HIST_LEN-1:0] hist_o
);

  logic [HIST_LEN-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= {hist_q[HIST_LEN-2:0], bit_in};
  end

  assign hist_o = hist_q;

  // R6: outcome lands in bit 0, older bits move up by one
  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (hist_q[0] == $past(bit_in)) &&
                 (hist_q[HIST_LEN-1:1] == $past(hist_q[HIST_LEN-2:0])));

  // R7: no update, no history movement
  assert_hist_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/gsel_counter_table.sv
module gsel_counter_table
  import gsel_pkg::*;
#(
  parameter int IDX_W  = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);

  ctr_t ctr_q [DEPTH];
  ctr_t wr_old;

  assign wr_old   = ctr_q[wr_idx_i];
  assign rd_ctr_o = ctr_q[rd_idx_i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
    end else if (wr_en_i) begin
      ctr_q[wr_idx_i] <= ctr_step(wr_old, wr_taken_i);
    end
  end

  // R3: taken moves the counter up by one below the ceiling
  assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_taken_i && wr_old != 2'd3) |=>
      ctr_q[$past(wr_idx_i)] == 2'($past(wr_old) + 2'd1));

  // R3: ceiling holds
  assert_sat_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_taken_i && wr_old == 2'd3) |=> ctr_q[$past(wr_idx_i)] == 2'd3);

  // R4: not-taken moves the counter down by one above the floor
  assert_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_taken_i && wr_old != 2'd0) |=>
      ctr_q[$past(wr_idx_i)] == 2'($past(wr_old) - 2'd1));

  // R4: floor holds
  assert_sat_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_taken_i && wr_old == 2'd0) |=> ctr_q[$past(wr_idx_i)] == 2'd0);

  // R7: an idle cycle leaves the read-side entry unchanged
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ctr_q[$past(rd_idx_i)] == $past(rd_ctr_o));

endmodule

// File: rtl/gsel_predictor.sv
module gsel_predictor
  import gsel_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ALIGN     = 2,
  parameter int ADDR_BITS = 4,
  parameter int HIST_LEN  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   lk_addr_i,
  output logic                lk_pred_o,
  output logic [1:0]          lk_ctr_o,
  output logic [HIST_LEN-1:0] lk_hist_o,
  input  logic                up_valid_i,
  input  logic [ADDR_W-1:0]   up_addr_i,
  input  logic [HIST_LEN-1:0] up_hist_i,
  input  logic                up_taken_i
);

  localparam int IDX_W = ADDR_BITS + HIST_LEN;

  logic [HIST_LEN-1:0] ghist;
  logic [IDX_W-1:0]    lk_idx;
  logic [IDX_W-1:0]    up_idx;
  ctr_t                lk_ctr;
  logic                collide;

  gsel_history #(.HIST_LEN(HIST_LEN)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (up_valid_i),
    .bit_in   (up_taken_i),
    .hist_o   (ghist)
  );

  gsel_index_gen #(.ADDR_W(ADDR_W), .ALIGN(ALIGN), .ADDR_BITS(ADDR_BITS),
                   .HIST_LEN(HIST_LEN)) u_lk_index (
    .addr_i (lk_addr_i),
    .hist_i (ghist),
    .idx_o  (lk_idx)
  );

  gsel_index_gen #(.ADDR_W(ADDR_W), .ALIGN(ALIGN), .ADDR_BITS(ADDR_BITS),
                   .HIST_LEN(HIST_LEN)) u_up_index (
    .addr_i (up_addr_i),
    .hist_i (up_hist_i),
    .idx_o  (up_idx)
  );

  gsel_counter_table #(.IDX_W(IDX_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx_i   (lk_idx),
    .rd_ctr_o   (lk_ctr),
    .wr_en_i    (up_valid_i),
    .wr_idx_i   (up_idx),
    .wr_taken_i (up_taken_i)
  );

  assign collide   = up_valid_i && (up_idx == lk_idx);
  assign lk_ctr_o  = lk_ctr;
  assign lk_pred_o = lk_ctr[1];
  assign lk_hist_o = ghist;

  // R9: in a colliding cycle the lookup answer still holds the pre-update
  // value at the edge, so the entry differs afterwards unless saturated
  assert_collide_old_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && !(up_taken_i && lk_ctr == 2'd3) && !(!up_taken_i && lk_ctr == 2'd0))
      |=> $past(lk_ctr) != u_table.ctr_q[$past(up_idx)]);

endmodule

// File: tb/tb_gsel_predictor.sv
`timescale 1ns/1ps
module tb_gsel_predictor;

  localparam int AW = 32, AL = 2, AB = 4, HL = 4;
  localparam int NENT = 1 << (AB + HL);

  logic          clk = 0;
  logic          rst_n = 0;
  logic [AW-1:0] lk_addr = '0;
  logic          lk_pred;
  logic [1:0]    lk_ctr;
  logic [HL-1:0] lk_hist;
  logic          up_valid = 0;
  logic [AW-1:0] up_addr = '0;
  logic [HL-1:0] up_hist = '0;
  logic          up_taken = 0;

  always #2.5 clk = ~clk;

  gsel_predictor #(.ADDR_W(AW), .ALIGN(AL), .ADDR_BITS(AB), .HIST_LEN(HL)) dut (
    .clk(clk), .rst_n(rst_n), .lk_addr_i(lk_addr), .lk_pred_o(lk_pred),
    .lk_ctr_o(lk_ctr), .lk_hist_o(lk_hist), .up_valid_i(up_valid),
    .up_addr_i(up_addr), .up_hist_i(up_hist), .up_taken_i(up_taken));

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  int m_ctr [NENT];
  int m_hist = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int ent(int slice, int h);
    return (slice % (1 << AB)) * (1 << HL) + h;
  endfunction

  function automatic logic [AW-1:0] mk_addr(int slice, logic [15:0] junk);
    return {junk, 16'h0} | AW'(slice << AL) | AW'(junk[1:0]) | AW'({junk[7:0], 8'h0} << (AL + AB));
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic probe(int slice, string req);
    @(negedge clk);
    up_valid = 0;
    step_lfsr();
    lk_addr = mk_addr(slice, lfsr);
    #1;
    chk({req, " ctr"}, int'(lk_ctr), m_ctr[ent(slice, m_hist)]);
    chk({req, " pred"}, int'(lk_pred), m_ctr[ent(slice, m_hist)] / 2);
    chk({req, " hist"}, int'(lk_hist), m_hist);
  endtask

  task automatic sweep(string req);
    for (int s = 0; s < (1 << AB); s++) probe(s, req);
  endtask

  task automatic model_train(int slice, int h, bit t);
    int e = ent(slice, h);
    if (t && m_ctr[e] < 3) m_ctr[e] = m_ctr[e] + 1;
    else if (!t && m_ctr[e] > 0) m_ctr[e] = m_ctr[e] - 1;
    m_hist = ((m_hist << 1) | int'(t)) % (1 << HL);
  endtask

  task automatic update(int slice, int h, bit t);
    @(negedge clk);
    step_lfsr();
    up_addr = mk_addr(slice, lfsr);
    up_hist = HL'(h);
    up_taken = t;
    up_valid = 1;
    @(posedge clk);
    model_train(slice, h, t);
    @(negedge clk);
    up_valid = 0;
  endtask

  // drive the global history to a chosen value through a spare slice
  task automatic set_hist(int target);
    for (int b = HL - 1; b >= 0; b--) update(15, m_hist, target[b]);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NENT; i++) m_ctr[i] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 R2 R5: reset state, every slice with junk address bits
    sweep("R1 R2 R5 reset");

    // R3: increment and ceiling on slice 3, history 0
    for (int k = 0; k < 5; k++) begin
      update(3, 0, 1);
      set_hist(0);
      @(negedge clk); lk_addr = mk_addr(3, lfsr); #1;
      chk("R3 taken step", int'(lk_ctr), (k + 2 > 3) ? 3 : k + 2);
    end
    // R4: decrement and floor, history kept at zero
    for (int k = 0; k < 5; k++) begin
      update(3, 0, 0);
      set_hist(0);
      @(negedge clk); lk_addr = mk_addr(3, lfsr); #1;
      chk("R4 not-taken step", int'(lk_ctr), (2 - k < 0) ? 0 : 2 - k);
    end

    // R6: history shift pattern
    set_hist(0);
    update(5, m_hist, 1); #1 chk("R6 shift", int'(lk_hist), 1);
    update(5, m_hist, 0); #1 chk("R6 shift", int'(lk_hist), 2);
    update(5, m_hist, 1); #1 chk("R6 shift", int'(lk_hist), 5);
    update(5, m_hist, 1); #1 chk("R6 shift", int'(lk_hist), 11);
    update(5, m_hist, 0); #1 chk("R6 drop oldest", int'(lk_hist), 6);

    // R8: train with supplied history 5 while the global history is 6
    update(8, 5, 1);
    set_hist(5);
    @(negedge clk); lk_addr = mk_addr(8, lfsr); #1;
    chk("R8 supplied history", int'(lk_ctr), 2);
    sweep("R8 sweep");

    // R9: same-entry collision
    @(negedge clk);
    lk_addr = mk_addr(7, lfsr);
    up_addr = mk_addr(7, 16'h1234);
    up_hist = HL'(m_hist);
    up_taken = 1;
    up_valid = 1;
    #1;
    chk("R9 old value", int'(lk_ctr), m_ctr[ent(7, m_hist)]);
    @(posedge clk);
    model_train(7, m_hist, 1);
    @(negedge clk); up_valid = 0;
    set_hist(5);
    @(negedge clk); lk_addr = mk_addr(7, lfsr); #1;
    chk("R9 new value", int'(lk_ctr), 2);

    // R7: idle lookups change nothing
    for (int r = 0; r < 3; r++) sweep("R7 idle");

    // R10: period-4 loop on slice 9
    for (int r = 0; r < 8; r++) begin
      update(9, m_hist, 1); update(9, m_hist, 1);
      update(9, m_hist, 1); update(9, m_hist, 0);
    end
    @(negedge clk); lk_addr = mk_addr(9, lfsr); #1;
    chk("R10 hist 1110 taken", int'(lk_pred), 1);
    chk("R10 hist value", int'(lk_hist), 14);
    update(9, m_hist, 1); update(9, m_hist, 1); update(9, m_hist, 1);
    @(negedge clk); lk_addr = mk_addr(9, lfsr); #1;
    chk("R10 hist 0111 not-taken", int'(lk_pred), 0);
    chk("R10 hist value", int'(lk_hist), 7);

    // R2 R3 R4 R6: pseudo-random training against the model
    for (int n = 0; n < 300; n++) begin
      step_lfsr();
      update(int'(lfsr[3:0]), (lfsr[4]) ? m_hist : int'(lfsr[9:6]), lfsr[5] ^ lfsr[11]);
      probe(int'(lfsr[15:12]), "R2 R3 R4 random");
    end
    sweep("R2 final");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule